// File: doc/BRIEF.md
# Mains Loss Detector

This block is a clocked stand-in for a retriggerable one-shot that watches the mains supply. Its input is a square wave at mains rate, for example 60 Hz with one rising edge about every 16.7 ms. The wave comes from an isolator and has no timing relationship to the system clock. The block brings that wave into the clock domain and finds its rising edges. Each rising edge restarts a timeout counter whose window is about two mains periods, 33 ms by default. When the counter expires, the block takes it as a loss of mains and drives a non-maskable interrupt request high.

The request is a level, not a pulse. It stays high for as long as rising edges are absent. It drops again on the first new rising edge. After reset the block waits for a first rising edge before it will flag a loss, so power-up never produces a false alarm. Detection completes about 33 ms after the last edge, which leaves most of a supply hold-up budget of at least 75 ms for saving state.

Top module: `pwrfail_watch`

## Requirements
- R1: While `rst` is high at a clock edge, `nmi_o` is low after that edge, and the block goes back to waiting for a first trigger.
- R2: After reset and before the first rising edge on `mains_pulse_i`, `nmi_o` stays low no matter how long the input stays quiet.
- R3: Only a 0-to-1 change on `mains_pulse_i` restarts the timeout. A falling edge does not restart it, and neither does a level held steady, whether high or low.
- R4: The timeout length is TIMEOUT = CLK_HZ × WINDOW_US / 1,000,000 clock cycles, with a minimum of 2. Let E0 be the first clock edge that samples a new high on `mains_pulse_i`. If no further rising edge follows, `nmi_o` is still low after edge E0+TIMEOUT+1 and is high after edge E0+TIMEOUT+2.
- R5: Rising edges spaced TIMEOUT clock cycles apart or closer keep `nmi_o` low. If a rising edge arrives on the same cycle as the expiry, the rising edge wins. A spacing of TIMEOUT+1 cycles lets `nmi_o` rise.
- R6: Once high, `nmi_o` stays high for as long as no rising edge arrives.
- R7: While `nmi_o` is high, a rising edge first sampled at edge E0 leaves `nmi_o` high after edge E0+1 and drives it low after edge E0+2.
- R8: An input high that lasts only one clock cycle counts as a full trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mains_pulse_i | input | 1 | Mains-rate square wave from the isolator; asynchronous to `clk` |
| nmi_o | output | 1 | Registered interrupt request; high while mains is judged lost |

## Verification
The bench builds the block with CLK_HZ = 1,000,000 and WINDOW_US = 24, which gives a timeout of 24 cycles. A real 33 ms window needs millions of cycles per loss, but this short window lets one run cover many losses, recoveries and resets. The short window also lets the bench test the exact expiry edge. It sends trigger spacings of exactly TIMEOUT and TIMEOUT+1 cycles, holds the input stuck high, and sends one-cycle pulses. It then compares `nmi_o` on the exact cycles that R4 and R7 give.

// File: rtl/pf_pkg.sv
package pf_pkg;

  // Supervisor states.
  typedef enum logic [1:0] {
    PF_ARMING = 2'd0,  // reset seen, waiting for the first trigger
    PF_LIVE   = 2'd1,  // triggers arriving, mains present
    PF_LOST   = 2'd2   // window lapsed, mains judged absent
  } pf_state_e;

  // Window length in clock cycles, never below 2.
  function automatic int unsigned pf_window_cycles(longint hz, longint us);
    longint c;
    c = (hz * us) / 64'd1000000;
    if (c < 2) c = 2;
    return int'(c);
  endfunction

endpackage

// File: rtl/pf_sync.sv
module pf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pf_rise.sv
module pf_rise (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/pf_gap_timer.sv
module pf_gap_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic lapse_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // Counts cycles since the last restart and saturates at LAST.
  always_ff @(posedge clk) begin
    if (rst || restart_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // A restart on the expiry cycle takes priority.
  assign lapse_o = (cnt_q == LAST) && !restart_i;
endmodule

// File: rtl/pwrfail_watch.sv
module pwrfail_watch
  import pf_pkg::*;
#(
  parameter longint CLK_HZ      = 100_000_000,
  parameter longint WINDOW_US   = 33_000,
  parameter int     SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mains_pulse_i,
  output logic nmi_o
);
  localparam int unsigned TIMEOUT_CYC = pf_window_cycles(CLK_HZ, WINDOW_US);

  logic      pulse_s;
  logic      rise_w;
  logic      lapse_w;
  pf_state_e state_q, state_d;

  pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(mains_pulse_i), .sync_o(pulse_s)
  );

  pf_rise u_rise (
    .clk(clk), .rst(rst), .level_i(pulse_s), .rise_o(rise_w)
  );

  pf_gap_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .restart_i(rise_w), .lapse_o(lapse_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PF_ARMING: if (rise_w)  state_d = PF_LIVE;
      PF_LIVE:   if (lapse_w) state_d = PF_LOST;
      PF_LOST:   if (rise_w)  state_d = PF_LIVE;
      default:                state_d = PF_ARMING;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PF_ARMING;
      nmi_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      nmi_o   <= (state_d == PF_LOST);
    end
  end
endmodule

// File: rtl/pwrfail_watch_chk.sv
module pwrfail_watch_chk
  import pf_pkg::*;
#(
  parameter longint CLK_HZ    = 100_000_000,
  parameter longint WINDOW_US = 33_000
) (
  input logic clk,
  input logic rst,
  input logic rise,
  input logic nmi
);
  localparam int unsigned LIMIT = pf_window_cycles(CLK_HZ, WINDOW_US);
  localparam int GW = $clog2(LIMIT + 1);
  localparam logic [GW-1:0] GMAX = GW'(LIMIT);

  logic          seen_q;
  logic          rst_d;
  logic [GW-1:0] gap_q;

  // Independent count of cycles since the last trigger, saturating.
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else if (rise) begin
      seen_q <= 1'b1;
      gap_q  <= '0;
    end else if (gap_q != GMAX) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> !nmi);

  assert_no_early_alarm_R2: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> !nmi);

  assert_alarm_only_after_window_R4: assert property (@(posedge clk) disable iff (rst)
    nmi |-> (gap_q == GMAX));

  assert_alarm_held_R6: assert property (@(posedge clk) disable iff (rst)
    (seen_q && gap_q == GMAX) |-> nmi);

  assert_trigger_clears_R7: assert property (@(posedge clk) disable iff (rst)
    rise |=> !nmi);
endmodule

bind pwrfail_watch pwrfail_watch_chk #(
  .CLK_HZ(CLK_HZ), .WINDOW_US(WINDOW_US)
) u_chk (
  .clk(clk), .rst(rst), .rise(rise_w), .nmi(nmi_o)
);

// File: tb/pwrfail_watch_bench.sv
module pwrfail_watch_bench;
  localparam longint CLK_HZ    = 1_000_000;
  localparam longint WINDOW_US = 24;
  localparam int     T         = int'((CLK_HZ * WINDOW_US) / 1000000);

  typedef struct {
    int    at;
    logic  val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mains = 1'b0;
  logic nmi;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwrfail_watch #(.CLK_HZ(CLK_HZ), .WINDOW_US(WINDOW_US)) u_pwrfail_watch (
    .clk(clk), .rst(rst), .mains_pulse_i(mains), .nmi_o(nmi)
  );

  // Monitor: compare at the falling edge, away from the active edge.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        checks++;
        if (nmi !== q[i].val) begin
          errors++;
          $display("FAIL %s cycle %0d nmi actual %b expected %b",
                   q[i].tag, cyc, nmi, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(int at, logic v, string tag);
    q.push_back('{at: at, val: v, tag: tag});
  endtask

  task automatic pulse(int hi, int lo);
    mains = 1'b1;
    tick(hi);
    mains = 1'b0;
    tick(lo);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int c;
    tick(3);
    rst = 1'b0;
    c = cyc;
    expect_at(c + 1, 1'b0, "R1");
    // R2: quiet input after reset never alarms.
    expect_at(c + T + 5, 1'b0, "R2");
    expect_at(c + 3 * T, 1'b0, "R2");
    tick(3 * T + 2);

    // R4/R3/R6: single trigger, falling edge ignored, alarm held.
    c = cyc;
    expect_at(c + T + 2, 1'b0, "R4");
    expect_at(c + T + 3, 1'b1, "R4");
    expect_at(c + T + 9, 1'b1, "R6");
    pulse(3, T + 12);

    // R7/R8: one-cycle trigger recovers.
    c = cyc;
    expect_at(c + 2, 1'b1, "R7");
    expect_at(c + 3, 1'b0, "R8");
    pulse(1, 10);

    // R5: steady train keeps the alarm low.
    for (int k = 0; k < 8; k++) begin
      c = cyc;
      expect_at(c + T / 2 + 1, 1'b0, "R5");
      pulse(2, T / 2);
    end
    c = cyc;
    expect_at(c + T + 2, 1'b0, "R4");
    expect_at(c + T + 3, 1'b1, "R4");
    pulse(2, T + 8);

    // R5 boundary: spacing T holds, spacing T+1 lapses.
    pulse(1, 10);
    c = cyc;
    expect_at(c + T + 3, 1'b0, "R5");
    pulse(2, T - 2);
    c = cyc;
    expect_at(c + T + 3, 1'b1, "R5");
    expect_at(c + T + 4, 1'b0, "R7");
    pulse(2, T - 1);
    pulse(2, T + 8);

    // R3: stuck-high input lapses; its falling edge does not recover.
    c = cyc;
    mains = 1'b1;
    expect_at(c + 3, 1'b0, "R7");
    expect_at(c + T + 3, 1'b1, "R3");
    tick(3 * T);
    mains = 1'b0;
    c = cyc;
    expect_at(c + T + 5, 1'b1, "R3");
    tick(T + 8);

    // R1: reset during alarm clears and rearms.
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    c = cyc;
    expect_at(c + 1, 1'b0, "R1");
    expect_at(c + T + 6, 1'b0, "R2");
    tick(2 * T);

    tick(5);
    if (q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard %0d pending actual %0d expected 0", q.size(), q.size());
    end
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end
endmodule